// File: doc/BRIEF.md
# Registered Word-Pairing Bus Exchanger

This block sits between one narrow data port (A) and a pair of narrow data ports (B1 and B2) of the same width, and moves words in both directions on a single clock. Going from A toward B, each B lane owns a capture register with its own active-low load strobe. Strobing lane 1 on one edge and lane 2 on a later edge leaves two successive A words side by side, so that B1 and B2 together carry a word of twice the width. Going from B toward A, one return register takes the B1 input or the B2 input and drives A. The choice comes from a registered select bit.

The select and all three active-low output enables are sampled into flops on the rising clock edge, so every change in direction or drive takes effect one edge after it is requested. Each bidirectional pin is split into an input, an output and a drive-enable, so no tristate sits inside the block. Whatever fabric surrounds the block resolves the shared wires. Reset is synchronous and active high.

The data paths are plain registered pins. They carry no valid/ready handshake, and nothing in the block can apply back-pressure. A word is taken on every edge whose strobe is low. The return register samples on every edge, so a consumer that needs a word must read it before the next edge replaces it.

Top module: `bx_exchanger`

## Requirements
- R1: On a rising edge with `cap1_n` low and reset low, `b1_out` takes the value of `a_in` present at that edge.
- R2: On a rising edge with `cap2_n` low and reset low, `b2_out` takes the value of `a_in` present at that edge.
- R3: A lane whose strobe is high at an edge keeps its previous contents, whatever the other lane and the other inputs do.
- R4: Strobing `cap1_n` with word X and then, on the next edge, `cap2_n` with word Y makes `{b1_out, b2_out}` equal `{X, Y}`.
- R5: The return register loads on every edge. It takes `b1_in` when the select sampled on the previous edge was 1, and `b2_in` when it was 0. `a_out` shows the register.
- R6: Each drive enable (`a_drv`, `b1_drv`, `b2_drv`) is 1 exactly when its own active-low enable input (`oea_n`, `oeb1_n`, `oeb2_n`) was 0 at the previous edge. No enable affects another port.
- R7: An edge with `rst` high clears both lane registers and the return register, drops all three drive enables to 0, and sets the registered select to 1. The first edge after reset therefore loads `b1_in` into the return register.
- R8: The data outputs show the register contents whether or not the matching drive enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Word arriving on the A side |
| a_out | output | W | Return register contents toward A |
| a_drv | output | 1 | Drive enable for the A wires |
| b1_in | input | W | Word arriving on the B1 side |
| b1_out | output | W | Lane 1 capture register |
| b1_drv | output | 1 | Drive enable for the B1 wires |
| b2_in | input | W | Word arriving on the B2 side |
| b2_out | output | W | Lane 2 capture register |
| b2_drv | output | 1 | Drive enable for the B2 wires |
| cap1_n | input | 1 | Lane 1 load strobe, active low |
| cap2_n | input | 1 | Lane 2 load strobe, active low |
| sel | input | 1 | Return source request: 1 = B1, 0 = B2 |
| oea_n | input | 1 | A drive request, active low |
| oeb1_n | input | 1 | B1 drive request, active low |
| oeb2_n | input | 1 | B2 drive request, active low |

## Verification
The most delicate coincidence is an edge on which a lane strobe fires, the select toggles and the return register samples, all at once. The return register must then use the select from the previous edge and the B pins rather than the freshly captured lane value. Both cases must hold in that same cycle. The bench provokes this by sweeping all 64 combinations of the two strobes, the select and the three enables, with distinct data on A, B1 and B2 at every step. A model in the bench, advanced edge by edge from the requirements, judges every output after each edge.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int unsigned NUM_LANES = 2;

  typedef struct packed {
    logic a;
    logic b1;
    logic b2;
  } bx_oe_t;
endpackage

// File: rtl/bx_lane_reg.sv
module bx_lane_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ld_n) q <= d;
  end

  // R1 R2
  lane_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_n |=> q == $past(d));

  // R3
  lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> $stable(q));

  // R7
  lane_clear_chk: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: rtl/bx_return_reg.sv
module bx_return_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] b1,
  input  logic [W-1:0] b2,
  output logic [W-1:0] q
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b1;
      q     <= '0;
    end else begin
      sel_q <= sel;
      q     <= sel_q ? b1 : b2;
    end
  end

  // R5
  ret_pick_b1_chk: assert property (@(posedge clk) disable iff (rst)
    sel_q |=> q == $past(b1));

  // R5
  ret_pick_b2_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> q == $past(b2));

  // R7
  ret_sel_reset_chk: assert property (@(posedge clk)
    rst |=> sel_q && q == '0);
endmodule

// File: rtl/bx_oe_ctrl.sv
module bx_oe_ctrl
  import bx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  bx_oe_t req_n,
  output bx_oe_t drv
);
  bx_oe_t req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '{a: 1'b1, b1: 1'b1, b2: 1'b1};
    else     req_q <= req_n;
  end

  assign drv = ~req_q;

  // R6
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drv == ~$past(req_n));

  // R7
  oe_reset_chk: assert property (@(posedge clk)
    rst |=> !drv.a && !drv.b1 && !drv.b2);
endmodule

// File: rtl/bx_exchanger.sv
module bx_exchanger
  import bx_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_drv,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_drv,
  input  logic         cap1_n,
  input  logic         cap2_n,
  input  logic         sel,
  input  logic         oea_n,
  input  logic         oeb1_n,
  input  logic         oeb2_n
);
  localparam int unsigned PAIR_W = NUM_LANES * W;

  logic [NUM_LANES-1:0] cap_n;
  logic [W-1:0]         lane_q [NUM_LANES];
  bx_oe_t               oe_req_n;
  bx_oe_t               oe_drv;

  assign cap_n = {cap2_n, cap1_n};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bx_lane_reg #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .ld_n (cap_n[g]),
      .d    (a_in),
      .q    (lane_q[g])
    );
  end

  assign b1_out = lane_q[0];
  assign b2_out = lane_q[1];

  bx_return_reg #(.W(W)) u_ret (
    .clk (clk),
    .rst (rst),
    .sel (sel),
    .b1  (b1_in),
    .b2  (b2_in),
    .q   (a_out)
  );

  assign oe_req_n = '{a: oea_n, b1: oeb1_n, b2: oeb2_n};

  bx_oe_ctrl u_oe (
    .clk   (clk),
    .rst   (rst),
    .req_n (oe_req_n),
    .drv   (oe_drv)
  );

  assign a_drv  = oe_drv.a;
  assign b1_drv = oe_drv.b1;
  assign b2_drv = oe_drv.b2;

  // R4
  pair_build_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap1_n && cap2_n) ##1 (!cap2_n && cap1_n) |=>
      PAIR_W'({b1_out, b2_out}) == PAIR_W'({$past(a_in, 2), $past(a_in)}));
endmodule

// File: tb/bx_exchanger_tb.sv
module bx_exchanger_tb;
  localparam int W = 12;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drv, b1_drv, b2_drv;
  logic cap1_n, cap2_n, sel, oea_n, oeb1_n, oeb2_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_b1, m_b2, m_a;
  logic m_sel, m_oea, m_oeb1, m_oeb2;

  always #2 clk = ~clk;

  bx_exchanger #(.W(W)) u_dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
    .cap1_n(cap1_n), .cap2_n(cap2_n), .sel(sel),
    .oea_n(oea_n), .oeb1_n(oeb1_n), .oeb2_n(oeb2_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Drive at negedge, advance the model at posedge, compare 1 ns later.
  task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b1,
                      input logic [W-1:0] b2, input logic [5:0] c);
    @(negedge clk);
    rst = r; a_in = a; b1_in = b1; b2_in = b2;
    {cap1_n, cap2_n, sel, oea_n, oeb1_n, oeb2_n} = c;
    @(posedge clk);
    if (r) begin
      m_b1 = '0; m_b2 = '0; m_a = '0; m_sel = 1'b1;
      m_oea = 1'b1; m_oeb1 = 1'b1; m_oeb2 = 1'b1;
    end else begin
      if (!c[5]) m_b1 = a;
      if (!c[4]) m_b2 = a;
      m_a = m_sel ? b1 : b2;
      m_sel = c[3];
      m_oea = c[2]; m_oeb1 = c[1]; m_oeb2 = c[0];
    end
    #1;
  endtask

  task automatic compare_all();
    chk(b1_out == m_b1, "R1/R3 lane1", int'(b1_out), int'(m_b1));
    chk(b2_out == m_b2, "R2/R3 lane2", int'(b2_out), int'(m_b2));
    chk(a_out == m_a, "R5 return", int'(a_out), int'(m_a));
    chk(a_drv == !m_oea, "R6 a_drv", int'(a_drv), int'(!m_oea));
    chk(b1_drv == !m_oeb1, "R6 b1_drv", int'(b1_drv), int'(!m_oeb1));
    chk(b2_drv == !m_oeb2, "R6 b2_drv", int'(b2_drv), int'(!m_oeb2));
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; a_in = '0; b1_in = '0; b2_in = '0;
    {cap1_n, cap2_n, sel, oea_n, oeb1_n, oeb2_n} = '1;
    step(1'b1, 12'h5A5, 12'h111, 12'h222, 6'b000000);
    step(1'b1, 12'h5A5, 12'h111, 12'h222, 6'b000000);
    // R7: reset state at the ports
    chk(b1_out == '0 && b2_out == '0 && a_out == '0, "R7 data cleared",
        int'({b1_out, b2_out}), 0);
    chk(!a_drv && !b1_drv && !b2_drv, "R7 drives off",
        int'({a_drv, b1_drv, b2_drv}), 0);
    // R7: first edge after reset takes b1_in although sel input is 0
    step(1'b0, 12'h000, 12'hABC, 12'hDEF, 6'b110000);
    chk(a_out == 12'hABC, "R7 select resets to b1", int'(a_out), 'hABC);
    compare_all();

    // R4: two sequential words form a pair
    step(1'b0, 12'h123, 12'h0, 12'h0, 6'b011111);
    step(1'b0, 12'h456, 12'h0, 12'h0, 6'b101111);
    chk({b1_out, b2_out} == 24'h123456, "R4 pair", int'({b1_out, b2_out}), 'h123456);
    // R3: both strobes high, new A word must not disturb the pair
    step(1'b0, 12'hFFF, 12'h0, 12'h0, 6'b111111);
    chk({b1_out, b2_out} == 24'h123456, "R3 hold", int'({b1_out, b2_out}), 'h123456);
    // R8: data visible while drives are off
    chk(!b1_drv && b1_out == 12'h123, "R8 data without drive", int'(b1_out), 'h123);

    // Sweep every control combination with varied data
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 64; c++) begin
        step(1'b0, W'((c * 13 + k * 7 + 5)) & MASK, W'((c * 29 + k * 3 + 1) * 5) & MASK,
             W'((c * 17 + k * 11 + 9) * 3) & MASK, 6'(c ^ (k * 21)));
        compare_all();
      end
    end

    // R7: reset mid-run clears state
    step(1'b1, 12'h777, 12'h888, 12'h999, 6'b000000);
    chk(b1_out == '0 && b2_out == '0 && a_out == '0 && !a_drv,
        "R7 mid-run reset", int'({b1_out, b2_out}), 0);
    compare_all();
    finish_run();
  end
endmodule